// File: doc/BRIEF.md
# Double-Buffer Pointer and Microprogram Launcher

This block tracks which of two data buffers in vector memory a host-side unpack engine should fill next, and starts a vector microprocessor on the buffer that was just filled. It holds a base pointer, an offset, the next-buffer pointer (`tops_o`) and the current-buffer pointer (`top_o`), all in quadword units. It also holds a one-bit flag that says which half of the double buffer is active.

Decoded commands arrive one per cycle with a 16-bit immediate. A start command does three things: it hands the next-buffer pointer over to the processor as the current buffer, it moves the next-buffer pointer to the other half, and it raises a one-cycle start strobe with a program counter. A call takes its program counter from the immediate. A continue takes the processor's present program counter. A busy bit stays high from each start until the processor reports stop. While busy is high, further starts are held off through `cmd_ready_o`.

Top module: `vdl_top`

## Requirements
- R1: After reset, `tops_o`, `top_o`, `dbf_o`, `busy_o`, `start_o` and `start_pc_o` are all zero, and `cmd_ready_o` is high.
- R2: An accepted set-offset command (op 0) loads the offset from `cmd_imm_i[9:0]`, clears `dbf_o` and copies the base pointer into `tops_o`, all visible the cycle after acceptance.
- R3: An accepted set-base command (op 1) loads the base from `cmd_imm_i[9:0]` and leaves `tops_o`, `top_o` and `dbf_o` unchanged. The new base becomes visible through later offset or start commands.
- R4: An accepted start (op 2 or 3) sets `top_o` to the previous `tops_o`. It sets `tops_o` to base when `dbf_o` was 1, or to (base + offset) mod 1024 when `dbf_o` was 0, and it inverts `dbf_o`.
- R5: An accepted call (op 2) pulses `start_o` high for exactly the next cycle, with `start_pc_o` equal to `cmd_imm_i[10:0]`. `start_pc_o` then holds until the next start.
- R6: An accepted continue (op 3) pulses `start_o` for the next cycle, with `start_pc_o` equal to `vu_pc_i` as sampled in the accepting cycle.
- R7: `busy_o` rises together with the start pulse and falls in the cycle after `vu_stop_i` is sampled high.
- R8: While `busy_o` is high, a start command sees `cmd_ready_o` low and changes no output. Offset and base commands are still accepted while busy.
- R9: `vu_stop_i` while `busy_o` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present |
| cmd_op_i | input | 2 | 0 set offset, 1 set base, 2 call, 3 continue |
| cmd_imm_i | input | 16 | Command immediate |
| cmd_ready_o | output | 1 | Command accepted this cycle when valid |
| vu_pc_i | input | 11 | Processor's current program counter |
| vu_stop_i | input | 1 | Processor finished |
| tops_o | output | 10 | Next-buffer pointer |
| top_o | output | 10 | Current-buffer pointer |
| dbf_o | output | 1 | Double-buffer flag |
| start_o | output | 1 | One-cycle start strobe |
| start_pc_o | output | 11 | Program counter for the start |
| busy_o | output | 1 | Processor running |

## Verification
The hardest case to reach is a start that arrives while the processor is still running. The same holds for a set-offset that lands between two starts and resets the flag in mid-alternation. The random stimulus holds stop low in most cycles, so busy periods last long enough for stalled starts and for base and offset updates during busy. Directed sequences check base + offset wrapping past 1023, and a stop that arrives while idle.

// File: rtl/vdl_pkg.sv
package vdl_pkg;
  typedef enum logic [1:0] {
    OP_OFFSET = 2'd0,
    OP_BASE   = 2'd1,
    OP_CALL   = 2'd2,
    OP_CONT   = 2'd3
  } vdl_op_e;
endpackage

// File: rtl/vdl_cmd_gate.sv
module vdl_cmd_gate (
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic       busy_i,
  output logic       ready_o,
  output logic       acc_offset_o,
  output logic       acc_base_o,
  output logic       acc_start_o,
  output logic       acc_cont_o
);
  import vdl_pkg::*;
  logic is_start;
  logic acc;

  assign is_start = (op_i == OP_CALL) || (op_i == OP_CONT);
  // starts stall while the processor runs
  assign ready_o  = !(is_start && busy_i);
  assign acc      = valid_i && ready_o;

  assign acc_offset_o = acc && (op_i == OP_OFFSET);
  assign acc_base_o   = acc && (op_i == OP_BASE);
  assign acc_start_o  = acc && is_start;
  assign acc_cont_o   = acc && (op_i == OP_CONT);
endmodule

// File: rtl/vdl_ptr_regs.sv
module vdl_ptr_regs #(
  parameter int PTR_W = 10,
  parameter int IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_offset_i,
  input  logic             acc_base_i,
  input  logic             acc_start_i,
  input  logic [IMM_W-1:0] imm_i,
  output logic [PTR_W-1:0] tops_o,
  output logic [PTR_W-1:0] top_o,
  output logic             dbf_o
);
  logic [PTR_W-1:0] base_q, ofst_q, tops_q, top_q;
  logic             dbf_q;
  logic [PTR_W-1:0] imm_ptr;
  logic [PTR_W-1:0] alt_ptr;

  assign imm_ptr = imm_i[PTR_W-1:0];
  assign alt_ptr = base_q + ofst_q;  // wraps modulo 2**PTR_W

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      ofst_q <= '0;
      tops_q <= '0;
      top_q  <= '0;
      dbf_q  <= 1'b0;
    end else if (acc_offset_i) begin
      ofst_q <= imm_ptr;
      dbf_q  <= 1'b0;
      tops_q <= base_q;
    end else if (acc_base_i) begin
      base_q <= imm_ptr;
    end else if (acc_start_i) begin
      top_q  <= tops_q;
      tops_q <= dbf_q ? base_q : alt_ptr;
      dbf_q  <= !dbf_q;
    end
  end

  assign tops_o = tops_q;
  assign top_o  = top_q;
  assign dbf_o  = dbf_q;
endmodule

// File: rtl/vdl_launch_ctrl.sv
module vdl_launch_ctrl #(
  parameter int PC_W  = 11,
  parameter int IMM_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_start_i,
  input  logic             acc_cont_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [PC_W-1:0]  vu_pc_i,
  input  logic             vu_stop_i,
  output logic             start_o,
  output logic [PC_W-1:0]  start_pc_o,
  output logic             busy_o
);
  logic            start_q, busy_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      busy_q  <= 1'b0;
      pc_q    <= '0;
    end else begin
      start_q <= acc_start_i;
      if (acc_start_i) begin
        busy_q <= 1'b1;
        pc_q   <= acc_cont_i ? vu_pc_i : imm_i[PC_W-1:0];
      end else if (vu_stop_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign start_o    = start_q;
  assign start_pc_o = pc_q;
  assign busy_o     = busy_q;
endmodule

// File: rtl/vdl_top.sv
module vdl_top #(
  parameter int PTR_W = 10,
  parameter int IMM_W = 16,
  parameter int PC_W  = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [1:0]       cmd_op_i,
  input  logic [IMM_W-1:0] cmd_imm_i,
  output logic             cmd_ready_o,
  input  logic [PC_W-1:0]  vu_pc_i,
  input  logic             vu_stop_i,
  output logic [PTR_W-1:0] tops_o,
  output logic [PTR_W-1:0] top_o,
  output logic             dbf_o,
  output logic             start_o,
  output logic [PC_W-1:0]  start_pc_o,
  output logic             busy_o
);
  logic acc_offset, acc_base, acc_start, acc_cont;

  vdl_cmd_gate u_gate (
    .valid_i      (cmd_valid_i),
    .op_i         (cmd_op_i),
    .busy_i       (busy_o),
    .ready_o      (cmd_ready_o),
    .acc_offset_o (acc_offset),
    .acc_base_o   (acc_base),
    .acc_start_o  (acc_start),
    .acc_cont_o   (acc_cont)
  );

  vdl_ptr_regs #(.PTR_W(PTR_W), .IMM_W(IMM_W)) u_ptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .acc_offset_i (acc_offset),
    .acc_base_i   (acc_base),
    .acc_start_i  (acc_start),
    .imm_i        (cmd_imm_i),
    .tops_o       (tops_o),
    .top_o        (top_o),
    .dbf_o        (dbf_o)
  );

  vdl_launch_ctrl #(.PC_W(PC_W), .IMM_W(IMM_W)) u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_start_i (acc_start),
    .acc_cont_i  (acc_cont),
    .imm_i       (cmd_imm_i),
    .vu_pc_i     (vu_pc_i),
    .vu_stop_i   (vu_stop_i),
    .start_o     (start_o),
    .start_pc_o  (start_pc_o),
    .busy_o      (busy_o)
  );
endmodule

// File: rtl/vdl_top_chk.sv
module vdl_top_chk #(
  parameter int PTR_W = 10,
  parameter int IMM_W = 16,
  parameter int PC_W  = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [1:0]       cmd_op_i,
  input logic [IMM_W-1:0] cmd_imm_i,
  input logic             cmd_ready_o,
  input logic [PC_W-1:0]  vu_pc_i,
  input logic             vu_stop_i,
  input logic [PTR_W-1:0] tops_o,
  input logic [PTR_W-1:0] top_o,
  input logic             dbf_o,
  input logic             start_o,
  input logic [PC_W-1:0]  start_pc_o,
  input logic             busy_o
);
  logic acc;
  assign acc = cmd_valid_i && cmd_ready_o;

  // R2
  offset_clears_dbf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd0) |=> !dbf_o);

  // R3
  base_keeps_ptrs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd1) |=> (tops_o == $past(tops_o) && top_o == $past(top_o)
                                   && dbf_o == $past(dbf_o)));

  // R4
  start_swaps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i[1]) |=> (top_o == $past(tops_o) && dbf_o != $past(dbf_o)));

  // R5
  call_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd2) |=> (start_o && start_pc_o == $past(cmd_imm_i[PC_W-1:0])));

  // R6
  cont_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && cmd_op_i == 2'd3) |=> (start_o && start_pc_o == $past(vu_pc_i)));

  // R7
  stop_clears_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && vu_stop_i) |=> !busy_o);

  // R7
  start_sets_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);

  // R8
  stall_when_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cmd_valid_i && cmd_op_i[1]) |-> !cmd_ready_o);

  // R5
  start_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
endmodule

bind vdl_top vdl_top_chk #(.PTR_W(PTR_W), .IMM_W(IMM_W), .PC_W(PC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_imm_i   (cmd_imm_i),
  .cmd_ready_o (cmd_ready_o),
  .vu_pc_i     (vu_pc_i),
  .vu_stop_i   (vu_stop_i),
  .tops_o      (tops_o),
  .top_o       (top_o),
  .dbf_o       (dbf_o),
  .start_o     (start_o),
  .start_pc_o  (start_pc_o),
  .busy_o      (busy_o)
);

// File: tb/vdl_top_tb_top.sv
module vdl_top_tb_top;
  localparam int PTR_W = 10;
  localparam int IMM_W = 16;
  localparam int PC_W  = 11;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             cmd_valid_i = 1'b0;
  logic [1:0]       cmd_op_i = '0;
  logic [IMM_W-1:0] cmd_imm_i = '0;
  logic             cmd_ready_o;
  logic [PC_W-1:0]  vu_pc_i = '0;
  logic             vu_stop_i = 1'b0;
  logic [PTR_W-1:0] tops_o, top_o;
  logic             dbf_o, start_o, busy_o;
  logic [PC_W-1:0]  start_pc_o;

  int checks = 0;
  int errors = 0;

  // model state
  logic [PTR_W-1:0] m_base = '0, m_ofst = '0, m_tops = '0, m_top = '0;
  logic             m_dbf = 1'b0, m_busy = 1'b0, m_start = 1'b0;
  logic [PC_W-1:0]  m_pc = '0;

  always #4 clk = !clk;

  vdl_top #(.PTR_W(PTR_W), .IMM_W(IMM_W), .PC_W(PC_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
    .cmd_imm_i(cmd_imm_i), .cmd_ready_o(cmd_ready_o), .vu_pc_i(vu_pc_i),
    .vu_stop_i(vu_stop_i), .tops_o(tops_o), .top_o(top_o), .dbf_o(dbf_o),
    .start_o(start_o), .start_pc_o(start_pc_o), .busy_o(busy_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic exp_ready(input logic v, input logic [1:0] op, input logic busy);
    return !(v && op[1] && busy);
  endfunction

  function automatic logic [PTR_W-1:0] exp_next_tops(input logic dbf,
      input logic [PTR_W-1:0] base, input logic [PTR_W-1:0] ofst);
    return dbf ? base : PTR_W'(base + ofst);
  endfunction

  task automatic check_all(input string req);
    check(req, "tops", int'(tops_o), int'(m_tops));
    check(req, "top", int'(top_o), int'(m_top));
    check(req, "dbf", int'(dbf_o), int'(m_dbf));
    check(req, "busy", int'(busy_o), int'(m_busy));
    check(req, "start", int'(start_o), int'(m_start));
    check(req, "start_pc", int'(start_pc_o), int'(m_pc));
  endtask

  // drive one cycle at negedge, apply model at posedge, check at next negedge
  task automatic step(input logic v, input logic [1:0] op, input logic [IMM_W-1:0] imm,
                      input logic [PC_W-1:0] pc, input logic stop, input string req);
    logic acc;
    cmd_valid_i = v; cmd_op_i = op; cmd_imm_i = imm; vu_pc_i = pc; vu_stop_i = stop;
    #1;
    check(req, "ready", int'(cmd_ready_o), int'(exp_ready(1'b1, op, m_busy)));
    acc = v && exp_ready(v, op, m_busy);
    @(posedge clk);
    m_start = 1'b0;
    if (acc) begin
      case (op)
        2'd0: begin m_ofst = imm[PTR_W-1:0]; m_dbf = 1'b0; m_tops = m_base; end
        2'd1: m_base = imm[PTR_W-1:0];
        default: begin
          m_top  = m_tops;
          m_tops = exp_next_tops(m_dbf, m_base, m_ofst);
          m_dbf  = !m_dbf;
          m_start = 1'b1;
          m_busy = 1'b1;
          m_pc   = (op == 2'd3) ? pc : imm[PC_W-1:0];
        end
      endcase
    end
    if (!(acc && op[1]) && stop) m_busy = 1'b0;
    @(negedge clk);
    check_all(req);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all("R1");
    check("R1", "ready", int'(cmd_ready_o), 1);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3 base alone leaves pointers
    step(1, 2'd1, 16'h0300, 0, 0, "R3");
    // R2 offset loads, tops <- base, dbf cleared
    step(1, 2'd0, 16'hF200, 0, 0, "R2");
    // R5 call from immediate; R4 tops -> base+ofst wrapping past 1023
    step(1, 2'd2, 16'hFABC, 11'h123, 0, "R5");
    step(0, 2'd0, 0, 0, 0, "R7");
    // R8 start while busy stalls; base and offset still accepted
    step(1, 2'd3, 0, 11'h055, 0, "R8");
    step(1, 2'd1, 16'h0010, 0, 0, "R8");
    step(1, 2'd2, 16'h0777, 0, 0, "R8");
    // R7 stop clears busy
    step(0, 2'd0, 0, 0, 1, "R7");
    // R9 stop while idle
    step(0, 2'd0, 0, 0, 1, "R9");
    // R6 continue uses processor pc; R4 dbf=1 -> tops=base
    step(1, 2'd3, 16'h0001, 11'h5A5, 0, "R6");
    step(0, 2'd0, 0, 0, 1, "R7");
    step(1, 2'd3, 16'h0002, 11'h3C3, 0, "R4");
    step(0, 2'd0, 0, 0, 1, "R7");
    // R2 offset mid-alternation resets flag
    step(1, 2'd0, 16'h0005, 0, 0, "R2");
    step(1, 2'd2, 16'h0044, 0, 0, "R4");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic v, stop;
      logic [1:0] op;
      string tag;
      v    = ($urandom % 4) != 0;
      op   = 2'($urandom);
      stop = ($urandom % 6) == 0;
      if (m_busy && v && op[1]) tag = "R8";
      else if (!v && stop && !m_busy) tag = "R9";
      else if (v && op == 2'd0) tag = "R2";
      else if (v && op == 2'd1) tag = "R3";
      else if (v && op == 2'd2) tag = "R5";
      else if (v && op == 2'd3) tag = "R6";
      else tag = "R7";
      step(v, op, 16'($urandom), 11'($urandom), stop, tag);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule